// File: doc/BRIEF.md
# Event-Driven Analog Limit Monitor

This block watches housekeeping samples as they arrive. Each sample comes with a channel index and a value. In the same clock edge that takes the sample, the block compares the value with the low and high limits stored for that channel. When the value lies outside that window, the block builds an alarm record and queues it on a valid/ready output. In parallel it pulses a response request that carries the channel's monitor class and the macro ID for the direction of the excursion.

Software loads the limit table one channel at a time. Each channel has a low limit, a high limit, a class and two macros (one for low, one for high). The block counts consecutive excursions in the same direction on each channel, so that a condition that persists can be told apart from a single glitch. A short FIFO holds alarms while the consumer stalls. A sticky flag shows that an alarm was lost.

Top module: `analog_limit_monitor`

## Requirements
- R1: After reset no alarm is valid, no response is pulsed and the overflow flag is 0. Every table entry resets to low limit 0, high limit all-ones, class 00 and macros 0, so no sample is out of limit until the table is configured.
- R2: Each sample strobe with a channel below 34 is compared exactly once. An excursion is queued at that clock edge and appears on the alarm port in the next cycle. A value with low <= value <= high (both ends inclusive) produces nothing.
- R3: A value below the low limit of channel n reports alarm ID 128+n. A value above the high limit reports ID 192+n. When both tests are true, the low test wins.
- R4: The first alarm value is the offending sample and the second is the limit it crossed.
- R5: The persistent flag (1) is set on the third and every later consecutive out-of-limit sample of a channel in the same direction. Otherwise the flag reads 0 (transient). An in-limit sample, or a change of direction, restarts the count.
- R6: Each excursion that requests a response pulses rsp_valid_o for one cycle, in the cycle after the sample. rsp_macro_o carries the channel's low macro for a low excursion and its high macro for a high excursion.
- R7: The class is encoded 00 nop, 01 redo, 10 shutdown, 11 reserved. A reserved class is emitted as 00. No response is pulsed when the emitted class is 00 and the selected macro is 0.
- R8: Up to 4 alarms wait while alm_ready_i is low. A new alarm that arrives while 4 are held, with no pop in that cycle, is dropped and sets alm_ovf_o. The flag stays set until reset. A pop in the same cycle makes room for the new alarm.
- R9: While alm_valid_o is high and alm_ready_i is low, the record holds steady. Alarms leave in the order they arrived.
- R10: A sample or table write with a channel index of 34 or more is ignored.
- R11: A table write changes the limits for samples in later cycles. A sample in the same cycle as the write is checked against the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_ch_i | input | 6 | Channel to write |
| cfg_lo_i | input | 16 | Low limit |
| cfg_hi_i | input | 16 | High limit |
| cfg_class_i | input | 2 | Monitor class |
| cfg_mac_lo_i | input | 4 | Macro ID for low excursions |
| cfg_mac_hi_i | input | 4 | Macro ID for high excursions |
| smp_valid_i | input | 1 | Sample strobe |
| smp_ch_i | input | 6 | Sample channel |
| smp_val_i | input | 16 | Sample value, unsigned |
| alm_valid_o | output | 1 | Alarm record valid |
| alm_ready_i | input | 1 | Alarm record accepted |
| alm_id_o | output | 8 | Alarm ID |
| alm_sample_o | output | 16 | Offending sample |
| alm_limit_o | output | 16 | Crossed limit |
| alm_persist_o | output | 1 | 1 = persistent, 0 = transient |
| alm_ovf_o | output | 1 | Sticky alarm-dropped flag |
| rsp_valid_o | output | 1 | Response request pulse |
| rsp_macro_o | output | 4 | Response macro ID |
| rsp_class_o | output | 2 | Response class |

## Verification
The assertions assume that the inputs are stable and known at each clock edge, and that no strobe is high during reset. For the persistence check they also assume that a channel's samples arrive with an in-limit result in between, or in a sequence the tracker can see. The stimulus drives every input on the falling edge and holds strobes low through reset. It uses channels 34 to 39 only to exercise rejection. It configures limits both with a proper window and with low above high, so that both branches of the low-wins rule are hit while the alarm values still keep their ordering.

// File: rtl/alm_pkg.sv
package alm_pkg;
  typedef enum logic [1:0] {
    CLS_NOP  = 2'b00,
    CLS_REDO = 2'b01,
    CLS_SHUT = 2'b10,
    CLS_RSVD = 2'b11
  } mon_class_e;

  localparam int unsigned ID_W       = 8;
  localparam int unsigned ID_LO_BASE = 128;
  localparam int unsigned ID_HI_BASE = 192;

  function automatic mon_class_e norm_class(input mon_class_e c);
    return (c == CLS_RSVD) ? CLS_NOP : c;
  endfunction
endpackage

// File: rtl/limit_table.sv
module limit_table
  import alm_pkg::*;
#(
  parameter int unsigned N_CH   = 34,
  parameter int unsigned CH_W   = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MAC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   wch_i,
  input  logic [DATA_W-1:0] wlo_i,
  input  logic [DATA_W-1:0] whi_i,
  input  mon_class_e        wcls_i,
  input  logic [MAC_W-1:0]  wmlo_i,
  input  logic [MAC_W-1:0]  wmhi_i,
  input  logic [CH_W-1:0]   rch_i,
  output logic [DATA_W-1:0] rlo_o,
  output logic [DATA_W-1:0] rhi_o,
  output mon_class_e        rcls_o,
  output logic [MAC_W-1:0]  rmlo_o,
  output logic [MAC_W-1:0]  rmhi_o
);
  logic [DATA_W-1:0] lo_q  [N_CH];
  logic [DATA_W-1:0] hi_q  [N_CH];
  mon_class_e        cls_q [N_CH];
  logic [MAC_W-1:0]  mlo_q [N_CH];
  logic [MAC_W-1:0]  mhi_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g]  <= '0;
        hi_q[g]  <= '1;
        cls_q[g] <= CLS_NOP;
        mlo_q[g] <= '0;
        mhi_q[g] <= '0;
      end else if (we_i && wch_i == CH_W'(g)) begin
        lo_q[g]  <= wlo_i;
        hi_q[g]  <= whi_i;
        cls_q[g] <= wcls_i;
        mlo_q[g] <= wmlo_i;
        mhi_q[g] <= wmhi_i;
      end
    end
  end

  always_comb begin
    rlo_o  = '0;
    rhi_o  = '1;
    rcls_o = CLS_NOP;
    rmlo_o = '0;
    rmhi_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (rch_i == CH_W'(i)) begin
        rlo_o  = lo_q[i];
        rhi_o  = hi_q[i];
        rcls_o = cls_q[i];
        rmlo_o = mlo_q[i];
        rmhi_o = mhi_q[i];
      end
    end
  end
endmodule

// File: rtl/persist_tracker.sv
module persist_tracker #(
  parameter int unsigned N_CH      = 34,
  parameter int unsigned CH_W      = 6,
  parameter int unsigned PERSIST_N = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            exc_i,
  input  logic            dir_i,
  output logic            persist_o
);
  localparam int unsigned CNT_W = $clog2(PERSIST_N + 1);

  logic [CNT_W-1:0] cnt_q [N_CH];
  logic             dir_q [N_CH];
  logic [CNT_W-1:0] cur_cnt, nxt_cnt;
  logic             cur_dir;

  always_comb begin
    cur_cnt = '0;
    cur_dir = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch_i == CH_W'(i)) begin
        cur_cnt = cnt_q[i];
        cur_dir = dir_q[i];
      end
    end
    if (!exc_i)                                  nxt_cnt = '0;
    else if (cur_cnt != '0 && cur_dir == dir_i)  nxt_cnt = (cur_cnt == CNT_W'(PERSIST_N)) ? cur_cnt : cur_cnt + 1'b1;
    else                                         nxt_cnt = CNT_W'(1);
  end

  assign persist_o = exc_i && (nxt_cnt >= CNT_W'(PERSIST_N));

  for (genvar g = 0; g < N_CH; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
        dir_q[g] <= 1'b0;
      end else if (upd_i && ch_i == CH_W'(g)) begin
        cnt_q[g] <= nxt_cnt;
        dir_q[g] <= dir_i;
      end
    end
  end

  // R5
  restart_after_inlimit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && $past(upd_i && !exc_i) && ch_i == $past(ch_i)) |-> !persist_o);
endmodule

// File: rtl/alarm_fifo.sv
module alarm_fifo #(
  parameter int unsigned W     = 41,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop, accept;

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign pop     = valid_o && ready_i;
  assign accept  = push_i && ((cnt_q != CNT_W'(DEPTH)) || pop);

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (accept) wr_q <= inc(wr_q);
      if (pop)    rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(pop);
      if (push_i && !accept) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_q] <= data_i;
  end

  // R9
  hold_when_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/analog_limit_monitor.sv
module analog_limit_monitor
  import alm_pkg::*;
#(
  parameter int unsigned N_CH       = 34,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned MAC_W      = 4,
  parameter int unsigned PERSIST_N  = 3,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned CH_W      = $clog2(N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [DATA_W-1:0] cfg_lo_i,
  input  logic [DATA_W-1:0] cfg_hi_i,
  input  logic [1:0]        cfg_class_i,
  input  logic [MAC_W-1:0]  cfg_mac_lo_i,
  input  logic [MAC_W-1:0]  cfg_mac_hi_i,
  input  logic              smp_valid_i,
  input  logic [CH_W-1:0]   smp_ch_i,
  input  logic [DATA_W-1:0] smp_val_i,
  output logic              alm_valid_o,
  input  logic              alm_ready_i,
  output logic [ID_W-1:0]   alm_id_o,
  output logic [DATA_W-1:0] alm_sample_o,
  output logic [DATA_W-1:0] alm_limit_o,
  output logic              alm_persist_o,
  output logic              alm_ovf_o,
  output logic              rsp_valid_o,
  output logic [MAC_W-1:0]  rsp_macro_o,
  output logic [1:0]        rsp_class_o
);
  localparam int unsigned REC_W = ID_W + 2 * DATA_W + 1;

  logic [DATA_W-1:0] t_lo, t_hi;
  mon_class_e        t_cls, cls_n;
  logic [MAC_W-1:0]  t_mlo, t_mhi, sel_mac;
  logic              smp_ok, cfg_ok, below, above, exc, persist, push, rsp_go;
  logic [ID_W-1:0]   id;
  logic [REC_W-1:0]  rec_in, rec_out;

  assign smp_ok = smp_valid_i && (smp_ch_i < CH_W'(N_CH));
  assign cfg_ok = cfg_we_i && (cfg_ch_i < CH_W'(N_CH));

  limit_table #(.N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W), .MAC_W(MAC_W)) u_table (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .we_i (cfg_ok), .wch_i (cfg_ch_i), .wlo_i (cfg_lo_i), .whi_i (cfg_hi_i),
    .wcls_i (mon_class_e'(cfg_class_i)), .wmlo_i (cfg_mac_lo_i), .wmhi_i (cfg_mac_hi_i),
    .rch_i (smp_ch_i),
    .rlo_o (t_lo), .rhi_o (t_hi), .rcls_o (t_cls), .rmlo_o (t_mlo), .rmhi_o (t_mhi)
  );

  // low test has priority when limits are inverted
  assign below = smp_val_i < t_lo;
  assign above = !below && (smp_val_i > t_hi);
  assign exc   = below || above;

  persist_tracker #(.N_CH(N_CH), .CH_W(CH_W), .PERSIST_N(PERSIST_N)) u_persist (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .upd_i (smp_ok), .ch_i (smp_ch_i), .exc_i (exc), .dir_i (above),
    .persist_o (persist)
  );

  assign id     = below ? ID_W'(ID_LO_BASE) + ID_W'(smp_ch_i)
                        : ID_W'(ID_HI_BASE) + ID_W'(smp_ch_i);
  assign rec_in = {id, smp_val_i, (below ? t_lo : t_hi), persist};
  assign push   = smp_ok && exc;

  alarm_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (push), .data_i (rec_in),
    .valid_o (alm_valid_o), .ready_i (alm_ready_i),
    .data_o (rec_out), .ovf_o (alm_ovf_o)
  );

  assign {alm_id_o, alm_sample_o, alm_limit_o, alm_persist_o} = rec_out;

  assign cls_n   = norm_class(t_cls);
  assign sel_mac = above ? t_mhi : t_mlo;
  assign rsp_go  = push && !(cls_n == CLS_NOP && sel_mac == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_macro_o <= '0;
      rsp_class_o <= '0;
    end else begin
      rsp_valid_o <= rsp_go;
      if (rsp_go) begin
        rsp_macro_o <= sel_mac;
        rsp_class_o <= cls_n;
      end
    end
  end

  // R4
  low_value_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_valid_o && alm_id_o < ID_W'(ID_HI_BASE)) |-> (alm_sample_o < alm_limit_o));
  // R4
  high_value_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_valid_o && alm_id_o >= ID_W'(ID_HI_BASE)) |-> (alm_sample_o > alm_limit_o));
  // R3
  id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_valid_o |-> (alm_id_o >= ID_W'(ID_LO_BASE)));
  // R7
  rsp_class_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_class_o != 2'b11));
  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(smp_valid_i));
endmodule

// File: tb/analog_limit_monitor_tb.sv
`timescale 1ns/1ps
module analog_limit_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_ch = '0;
  logic [15:0] cfg_lo = '0, cfg_hi = '0;
  logic [1:0]  cfg_cls = '0;
  logic [3:0]  cfg_mlo = '0, cfg_mhi = '0;
  logic        smp_v = 1'b0;
  logic [5:0]  smp_ch = '0;
  logic [15:0] smp_val = '0;
  logic        alm_ready = 1'b1;
  logic        alm_valid, alm_persist, alm_ovf, rsp_valid;
  logic [7:0]  alm_id;
  logic [15:0] alm_sample, alm_limit;
  logic [3:0]  rsp_macro;
  logic [1:0]  rsp_class;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  analog_limit_monitor u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .cfg_we_i (cfg_we), .cfg_ch_i (cfg_ch), .cfg_lo_i (cfg_lo), .cfg_hi_i (cfg_hi),
    .cfg_class_i (cfg_cls), .cfg_mac_lo_i (cfg_mlo), .cfg_mac_hi_i (cfg_mhi),
    .smp_valid_i (smp_v), .smp_ch_i (smp_ch), .smp_val_i (smp_val),
    .alm_valid_o (alm_valid), .alm_ready_i (alm_ready),
    .alm_id_o (alm_id), .alm_sample_o (alm_sample), .alm_limit_o (alm_limit),
    .alm_persist_o (alm_persist), .alm_ovf_o (alm_ovf),
    .rsp_valid_o (rsp_valid), .rsp_macro_o (rsp_macro), .rsp_class_o (rsp_class)
  );

  // reference model
  typedef struct { int id; int s; int l; bit p; } rec_t;
  rec_t q[$];
  int m_lo[34], m_hi[34], m_cls[34], m_mlo[34], m_mhi[34], m_cnt[34], m_dir[34];
  bit m_ovf, m_rsp_v;
  int m_mac, m_rcls;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 34; i++) begin
        m_lo[i] = 0; m_hi[i] = 65535; m_cls[i] = 0; m_mlo[i] = 0; m_mhi[i] = 0;
        m_cnt[i] = 0; m_dir[i] = 0;
      end
      m_ovf = 0; m_rsp_v = 0; m_mac = 0; m_rcls = 0;
    end else begin
      m_rsp_v = 0;
      if (q.size() > 0 && alm_ready) void'(q.pop_front());
      if (smp_v && smp_ch < 34) begin
        int c, v, d, mac, cn;
        bit lo_x, hi_x;
        rec_t r;
        c = smp_ch; v = smp_val;
        lo_x = v < m_lo[c];
        hi_x = !lo_x && v > m_hi[c];
        if (lo_x || hi_x) begin
          d = hi_x;
          if (m_cnt[c] > 0 && m_dir[c] == d) m_cnt[c] = (m_cnt[c] >= 3) ? 3 : m_cnt[c] + 1;
          else m_cnt[c] = 1;
          m_dir[c] = d;
          r.id = lo_x ? 128 + c : 192 + c;
          r.s = v;
          r.l = lo_x ? m_lo[c] : m_hi[c];
          r.p = m_cnt[c] >= 3;
          if (q.size() < 4) q.push_back(r); else m_ovf = 1;
          mac = d ? m_mhi[c] : m_mlo[c];
          cn = (m_cls[c] == 3) ? 0 : m_cls[c];
          if (!(cn == 0 && mac == 0)) begin m_rsp_v = 1; m_mac = mac; m_rcls = cn; end
        end else m_cnt[c] = 0;
      end
      if (cfg_we && cfg_ch < 34) begin
        m_lo[cfg_ch] = cfg_lo; m_hi[cfg_ch] = cfg_hi; m_cls[cfg_ch] = cfg_cls;
        m_mlo[cfg_ch] = cfg_mlo; m_mhi[cfg_ch] = cfg_mhi;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(alm_valid == (q.size() != 0), "R2", "alm_valid", alm_valid, q.size() != 0);
      if (alm_valid && q.size() != 0) begin
        chk(alm_id == q[0].id, "R3", "alm_id", alm_id, q[0].id);
        chk(alm_sample == q[0].s && alm_limit == q[0].l, "R4", "values",
            {alm_sample, alm_limit}, {q[0].s[15:0], q[0].l[15:0]});
        chk(alm_persist == q[0].p, "R5", "persist", alm_persist, q[0].p);
      end
      chk(alm_ovf == m_ovf, "R8", "ovf", alm_ovf, m_ovf);
      chk(rsp_valid == m_rsp_v, "R6", "rsp_valid", rsp_valid, m_rsp_v);
      if (rsp_valid && m_rsp_v) begin
        chk(rsp_macro == m_mac, "R6", "rsp_macro", rsp_macro, m_mac);
        chk(rsp_class == m_rcls, "R7", "rsp_class", rsp_class, m_rcls);
      end
    end
  end

  task automatic cfg(input int ch, input int lo, input int hi, input int cls, input int ml, input int mh);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 6'(ch); cfg_lo = 16'(lo); cfg_hi = 16'(hi);
    cfg_cls = 2'(cls); cfg_mlo = 4'(ml); cfg_mhi = 4'(mh);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic smp(input int ch, input int val);
    @(negedge clk);
    smp_v = 1; smp_ch = 6'(ch); smp_val = 16'(val);
    @(negedge clk);
    smp_v = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!alm_valid && !rsp_valid && !alm_ovf, "R1", "reset outputs",
        {alm_valid, rsp_valid, alm_ovf}, 0);
    rst_n = 1;
    // R1 unconfigured table raises nothing
    smp(3, 0); smp(3, 65535);
    chk(!alm_valid, "R1", "unconfigured alarm", alm_valid, 0);

    cfg(0, 100, 200, 0, 0, 2);
    cfg(1, 50, 60, 2, 1, 1);
    cfg(33, 10, 20, 1, 3, 4);
    cfg(5, 10, 20, 3, 0, 0);

    // R2/R3/R4 directed, stalled so record holds
    alm_ready = 0;
    smp(0, 50);
    chk(alm_valid && alm_id == 128, "R3", "low id ch0", alm_id, 128);
    chk(alm_sample == 50 && alm_limit == 100, "R4", "low values", alm_limit, 100);
    chk(!rsp_valid, "R7", "nop class macro 0 no rsp", rsp_valid, 0);
    alm_ready = 1;
    smp(0, 250);
    chk(rsp_valid && rsp_macro == 2 && rsp_class == 0, "R6", "high macro ch0", rsp_macro, 2);
    // R2 boundaries inclusive
    smp(33, 10); smp(33, 20);
    chk(!alm_valid && !rsp_valid, "R2", "inclusive limits", alm_valid, 0);
    smp(33, 9);
    chk(alm_id == 128 + 33 && rsp_class == 1 && rsp_macro == 3, "R3", "ch33 low", alm_id, 161);
    smp(33, 21);
    chk(alm_id == 192 + 33 && rsp_macro == 4, "R3", "ch33 high", alm_id, 225);
    // R5 persistence, restart on direction change and in-limit
    smp(1, 70); smp(1, 70);
    chk(!alm_persist, "R5", "second still transient", alm_persist, 0);
    smp(1, 70);
    chk(alm_persist, "R5", "third persistent", alm_persist, 1);
    smp(1, 70); smp(1, 10);
    chk(!alm_persist, "R5", "direction change", alm_persist, 0);
    smp(1, 55); smp(1, 10); smp(1, 10);
    chk(!alm_persist, "R5", "restart after in-limit", alm_persist, 0);
    // R7 reserved class with macro 0
    smp(5, 30);
    chk(alm_valid && !rsp_valid, "R7", "reserved as nop", rsp_valid, 0);
    // R10 out-of-range channel ignored
    smp(34, 0); smp(39, 65535);
    chk(!alm_valid && !rsp_valid, "R10", "bad channel sample", alm_valid, 0);
    cfg(34, 500, 600, 2, 5, 5);
    smp(33, 15);
    chk(!alm_valid, "R10", "bad channel write", alm_valid, 0);
    // R11 same-cycle write and sample
    @(negedge clk);
    cfg_we = 1; cfg_ch = 33; cfg_lo = 100; cfg_hi = 200; cfg_cls = 1; cfg_mlo = 3; cfg_mhi = 4;
    smp_v = 1; smp_ch = 33; smp_val = 15;
    @(negedge clk);
    cfg_we = 0; smp_v = 0;
    chk(!alm_valid, "R11", "old entry used", alm_valid, 0);
    smp(33, 15);
    chk(alm_valid && alm_limit == 100, "R11", "new entry used", alm_limit, 100);
    // R8/R9 overflow
    @(negedge clk); alm_ready = 0;
    for (int k = 0; k < 6; k++) smp(1, 70 + k);
    chk(alm_ovf, "R8", "overflow sticky", alm_ovf, 1);
    chk(alm_sample == 70, "R9", "oldest at head", alm_sample, 70);
    @(negedge clk); alm_ready = 1;
    repeat (6) @(negedge clk);
    chk(!alm_valid && alm_ovf, "R8", "drained, flag kept", alm_ovf, 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      alm_ready = ($urandom_range(0, 3) != 0);
      smp_v = ($urandom_range(0, 1) == 1);
      smp_ch = 6'($urandom_range(0, 39));
      smp_val = 16'($urandom_range(0, 300));
      cfg_we = ($urandom_range(0, 15) == 0);
      cfg_ch = 6'($urandom_range(0, 39));
      cfg_lo = 16'($urandom_range(0, 200));
      cfg_hi = 16'($urandom_range(50, 300));
      cfg_cls = 2'($urandom_range(0, 3));
      cfg_mlo = 4'($urandom_range(0, 2));
      cfg_mhi = 4'($urandom_range(0, 2));
    end
    @(negedge clk);
    smp_v = 0; cfg_we = 0; alm_ready = 1;
    repeat (8) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule